// File: doc/BRIEF.md
# GPIO Pad Configuration Write Guard

This block holds the software-visible configuration state for a bank of general-purpose I/O pads and decides, on every write, which bits are allowed to change. Each pad has a 32-bit configuration word, and two bank-wide bit vectors hold one bit per pad: a non-maskable-interrupt enable and a host-software ownership flag. A bank-wide lock vector also holds one bit per pad and lets firmware freeze a pad's setup once it has been programmed.

Protection for a pad is active only while its lock bit is set and the ownership input reports that the host owns the pad. A protected pad keeps its configuration fields, its interrupt-enable bit and its ownership flag. The low field of its configuration word still accepts writes, because that field carries the pad's drive (TX) level. Pads owned by any other agent ignore their lock bit. Access is through a simple request/write/byte-strobe bus. Every request is answered one cycle later with a ready pulse and registered read data.

Top module: `gpio_cfg_guard`

## Requirements
- R1: After reset, all configuration words, the interrupt-enable vector, the ownership-flag vector and the lock vector are zero, and `ready_o` is low.
- R2: The lock vector sits at byte address 0x118, and bit n locks pad n. Bits 31 down to NUM_PADS read as zero and ignore writes.
- R3: Writing a lock bit with 1 locks the pad, and writing it with 0 unlocks the pad again. The lock vector itself is never write-protected.
- R4: While pad n is protected, writes to its configuration word (byte address 4·n) leave bits 31:1 unchanged. Bit 0, the TX level, is still written.
- R5: While pad n is protected, bit n of the interrupt-enable vector (address 0x100) and bit n of the ownership-flag vector (address 0x104) ignore writes.
- R6: A pad is protected only when its lock bit is 1 and `host_own_i[n]` is 1 (host-owned). A pad with `host_own_i[n]` = 0 is fully writable whatever its lock bit holds.
- R7: Protection follows `host_own_i` with no delay: the first write after the ownership input changes already uses the new ownership.
- R8: Byte strobe `be_i[b]` enables bits 8b+7:8b. Bits that are protected keep their value even when other enabled bytes of the same write are updated.
- R9: Each request (`req_i` high) produces `ready_o` high exactly one cycle later, and `ready_o` is low otherwise. Read data appears on `rdata_o` in that same cycle. Unmapped or misaligned addresses read zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Access request, one per cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte address |
| be_i | input | 4 | Byte write strobes |
| wdata_i | input | 32 | Write data |
| host_own_i | input | NUM_PADS | Per-pad ownership, 1 = host owns the pad |
| ready_o | output | 1 | Response pulse, one cycle after the request |
| rdata_o | output | 32 | Registered read data, valid with ready_o |

## Verification
A write changes register state at the clock edge where the request is sampled. A read issued in the next cycle therefore already returns the new state. The response to every request (the ready pulse, plus data for reads) is due exactly one cycle after the request edge. The driver pushes each expectation just after the edge that samples its request. The monitor pops and compares one expectation at each following falling edge. Any ready pulse that arrives early, late, or with no request pending is therefore counted as a failure. Ownership changes are applied between requests, so R7 is checked by the very next write.

// File: rtl/gcg_pkg.sv
package gcg_pkg;
   localparam int unsigned WORD_W = 32;
   localparam int unsigned STRB_W = WORD_W / 8;

   typedef logic [WORD_W-1:0] word_t;
   typedef logic [STRB_W-1:0] strb_t;

   // Expand byte strobes into a per-bit write mask
   function automatic word_t strb_to_mask(input strb_t strb);
      word_t m;
      for (int b = 0; b < STRB_W; b++) begin
         m[8*b +: 8] = {8{strb[b]}};
      end
      return m;
   endfunction
endpackage

// File: rtl/gcg_lock_reg.sv
module gcg_lock_reg #(
   parameter int unsigned NUM_PADS = 24
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic                wr_i,
   input  logic [NUM_PADS-1:0] wmask_i,
   input  logic [NUM_PADS-1:0] wdata_i,
   output logic [NUM_PADS-1:0] lock_o
);
   logic [NUM_PADS-1:0] lock_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) lock_q <= '0;
      else if (wr_i) lock_q <= (lock_q & ~wmask_i) | (wdata_i & wmask_i);
   end

   assign lock_o = lock_q;

   for (genvar n = 0; n < NUM_PADS; n++) begin : g_chk
      // R3: lock bits follow written value in both directions
      p_lock_write_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (wr_i && wmask_i[n]) |=> (lock_q[n] == $past(wdata_i[n])));
   end
endmodule

// File: rtl/gcg_guard_vec.sv
module gcg_guard_vec #(
   parameter int unsigned NUM_PADS = 24
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic                wr_i,
   input  logic [NUM_PADS-1:0] wmask_i,
   input  logic [NUM_PADS-1:0] wdata_i,
   input  logic [NUM_PADS-1:0] prot_i,
   output logic [NUM_PADS-1:0] q_o
);
   logic [NUM_PADS-1:0] q;

   for (genvar n = 0; n < NUM_PADS; n++) begin : g_bit
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) q[n] <= 1'b0;
         else if (wr_i && wmask_i[n] && !prot_i[n]) q[n] <= wdata_i[n];
      end

      // R5: a protected pad's bit in this vector never moves
      p_bit_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
         prot_i[n] |=> $stable(q[n]));
   end

   assign q_o = q;
endmodule

// File: rtl/gcg_pad_cfg.sv
module gcg_pad_cfg
   import gcg_pkg::*;
#(
   parameter int unsigned TX_BITS = 1
) (
   input  logic  clk_i,
   input  logic  rst_ni,
   input  logic  wr_i,
   input  word_t wmask_i,
   input  word_t wdata_i,
   input  logic  prot_i,
   output word_t cfg_o
);
   localparam word_t FREE_MASK = word_t'((64'd1 << TX_BITS) - 64'd1);

   word_t cfg_q;
   word_t eff_mask;

   assign eff_mask = prot_i ? (wmask_i & FREE_MASK) : wmask_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cfg_q <= '0;
      else if (wr_i) cfg_q <= (cfg_q & ~eff_mask) | (wdata_i & eff_mask);
   end

   assign cfg_o = cfg_q;

   // R4: lockable fields hold while protected
   p_cfg_locked_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      prot_i |=> $stable(cfg_q[WORD_W-1:TX_BITS]));
   // R4: TX field always written when its byte is enabled
   p_tx_write_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_i && wmask_i[0]) |=> (cfg_q[0] == $past(wdata_i[0])));
   // R6: unprotected full-word write lands entirely
   p_cfg_free_write_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_i && !prot_i && (wmask_i == '1)) |=> (cfg_q == $past(wdata_i)));
   // R8: a byte without strobe keeps its value
   p_top_byte_kept_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!wr_i || !wmask_i[WORD_W-1]) |=> $stable(cfg_q[WORD_W-1:WORD_W-8]));
endmodule

// File: rtl/gpio_cfg_guard.sv
module gpio_cfg_guard
   import gcg_pkg::*;
#(
   parameter int unsigned NUM_PADS = 24,
   parameter int unsigned ADDR_W   = 12,
   parameter int unsigned CFG_BASE = 32'h000,
   parameter int unsigned NMI_OFS  = 32'h100,
   parameter int unsigned HSW_OFS  = 32'h104,
   parameter int unsigned LOCK_OFS = 32'h118,
   parameter int unsigned TX_BITS  = 1
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic                req_i,
   input  logic                we_i,
   input  logic [ADDR_W-1:0]   addr_i,
   input  logic [3:0]          be_i,
   input  logic [31:0]         wdata_i,
   input  logic [NUM_PADS-1:0] host_own_i,
   output logic                ready_o,
   output logic [31:0]         rdata_o
);
   localparam logic [ADDR_W-1:0] A_LOCK = ADDR_W'(LOCK_OFS);
   localparam logic [ADDR_W-1:0] A_NMI  = ADDR_W'(NMI_OFS);
   localparam logic [ADDR_W-1:0] A_HSW  = ADDR_W'(HSW_OFS);
   localparam int unsigned CFG_END = CFG_BASE + 4 * NUM_PADS;

   // Elaboration-time parameter checks
   if (NUM_PADS < 1 || NUM_PADS > WORD_W) begin : g_bad_pads
      $error("NUM_PADS must lie in 1..32");
   end
   if (TX_BITS < 1 || TX_BITS >= WORD_W) begin : g_bad_tx
      $error("TX_BITS must lie in 1..31");
   end
   if ((CFG_BASE % 4) != 0 || (NMI_OFS % 4) != 0 || (HSW_OFS % 4) != 0 || (LOCK_OFS % 4) != 0)
   begin : g_bad_align
      $error("register offsets must be word aligned");
   end
   if ((CFG_END > NMI_OFS && CFG_BASE <= NMI_OFS) || (CFG_END > HSW_OFS && CFG_BASE <= HSW_OFS) ||
       (CFG_END > LOCK_OFS && CFG_BASE <= LOCK_OFS)) begin : g_bad_overlap
      $error("configuration window overlaps a vector register");
   end
   if ((64'd1 << ADDR_W) <= 64'(LOCK_OFS) || (64'd1 << ADDR_W) < 64'(CFG_END)) begin : g_bad_addr
      $error("ADDR_W too narrow for the register map");
   end

   word_t               wmask;
   logic                wr;
   logic                hit_lock, hit_nmi, hit_hsw;
   logic [NUM_PADS-1:0] hit_cfg;
   logic [NUM_PADS-1:0] lock_v, nmi_v, hsw_v, prot;
   word_t               cfg_v [NUM_PADS];
   word_t               rd_mux;
   word_t               rdata_q;
   logic                ready_q;
   logic                rd_lock_q;

   assign wmask    = strb_to_mask(be_i);
   assign wr       = req_i && we_i;
   assign hit_lock = (addr_i == A_LOCK);
   assign hit_nmi  = (addr_i == A_NMI);
   assign hit_hsw  = (addr_i == A_HSW);
   // Protection combines lock and current ownership with no register stage
   assign prot     = lock_v & host_own_i;

   gcg_lock_reg #(.NUM_PADS(NUM_PADS)) u_lock (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_i    (wr && hit_lock),
      .wmask_i (wmask[NUM_PADS-1:0]),
      .wdata_i (wdata_i[NUM_PADS-1:0]),
      .lock_o  (lock_v)
   );

   gcg_guard_vec #(.NUM_PADS(NUM_PADS)) u_nmi (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_i    (wr && hit_nmi),
      .wmask_i (wmask[NUM_PADS-1:0]),
      .wdata_i (wdata_i[NUM_PADS-1:0]),
      .prot_i  (prot),
      .q_o     (nmi_v)
   );

   gcg_guard_vec #(.NUM_PADS(NUM_PADS)) u_hsw (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_i    (wr && hit_hsw),
      .wmask_i (wmask[NUM_PADS-1:0]),
      .wdata_i (wdata_i[NUM_PADS-1:0]),
      .prot_i  (prot),
      .q_o     (hsw_v)
   );

   for (genvar n = 0; n < NUM_PADS; n++) begin : g_pad
      assign hit_cfg[n] = (addr_i == ADDR_W'(CFG_BASE + 4 * n));

      gcg_pad_cfg #(.TX_BITS(TX_BITS)) u_cfg (
         .clk_i   (clk_i),
         .rst_ni  (rst_ni),
         .wr_i    (wr && hit_cfg[n]),
         .wmask_i (wmask),
         .wdata_i (wdata_i),
         .prot_i  (prot[n]),
         .cfg_o   (cfg_v[n])
      );
   end

   always_comb begin
      rd_mux = '0;
      if (hit_lock) rd_mux = word_t'(lock_v);
      if (hit_nmi)  rd_mux = word_t'(nmi_v);
      if (hit_hsw)  rd_mux = word_t'(hsw_v);
      for (int n = 0; n < NUM_PADS; n++) begin
         if (hit_cfg[n]) rd_mux = cfg_v[n];
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ready_q   <= 1'b0;
         rdata_q   <= '0;
         rd_lock_q <= 1'b0;
      end else begin
         ready_q   <= req_i;
         rdata_q   <= (req_i && !we_i) ? rd_mux : '0;
         rd_lock_q <= req_i && !we_i && hit_lock;
      end
   end

   assign ready_o = ready_q;
   assign rdata_o = rdata_q;

   // R9: one response per request, exactly one cycle later
   p_ready_follows_req_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      req_i |=> ready_o);
   p_ready_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !req_i |=> !ready_o);

   if (NUM_PADS < WORD_W) begin : g_rsvd_chk
      // R2: reserved lock bits return zero
      p_lock_rsvd_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (ready_o && rd_lock_q) |-> (rdata_o[WORD_W-1:NUM_PADS] == '0));
   end
endmodule

// File: tb/sim_gpio_cfg_guard.sv
module sim_gpio_cfg_guard;
   localparam int NP = 24;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          req, we;
   logic [11:0]   addr;
   logic [3:0]    be_s;
   logic [31:0]   wdata;
   logic [NP-1:0] own;
   logic          ready_o;
   logic [31:0]   rdata_o;

   always #5 clk = ~clk;

   gpio_cfg_guard #(.NUM_PADS(NP)) u0 (
      .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
      .be_i(be_s), .wdata_i(wdata), .host_own_i(own),
      .ready_o(ready_o), .rdata_o(rdata_o)
   );

   // Reference model built from the requirements
   logic [31:0]   m_cfg [NP];
   logic [NP-1:0] m_lock, m_nmi, m_hsw;

   int n_chk = 0;
   int n_fail = 0;

   bit          q_rd  [$];
   logic [31:0] q_exp [$];
   string       q_tag [$];

   function automatic logic [31:0] bmask(input logic [3:0] b);
      logic [31:0] m;
      for (int i = 0; i < 4; i++) m[8*i +: 8] = {8{b[i]}};
      return m;
   endfunction

   function automatic logic [31:0] m_read(input logic [11:0] a);
      if (a == 12'h118) return 32'(m_lock);
      if (a == 12'h100) return 32'(m_nmi);
      if (a == 12'h104) return 32'(m_hsw);
      if (a[1:0] == 2'b00 && a < 12'(4 * NP)) return m_cfg[a >> 2];
      return 32'h0;
   endfunction

   function automatic void m_write(input logic [11:0] a, input logic [3:0] b, input logic [31:0] d);
      logic [31:0]   bm = bmask(b);
      logic [NP-1:0] pr = m_lock & own;
      logic [NP-1:0] vm = bm[NP-1:0] & ~pr;
      if (a == 12'h118) m_lock = (m_lock & ~bm[NP-1:0]) | (d[NP-1:0] & bm[NP-1:0]);
      else if (a == 12'h100) m_nmi = (m_nmi & ~vm) | (d[NP-1:0] & vm);
      else if (a == 12'h104) m_hsw = (m_hsw & ~vm) | (d[NP-1:0] & vm);
      else if (a[1:0] == 2'b00 && a < 12'(4 * NP)) begin
         if (pr[a >> 2]) bm = bm & 32'h1;
         m_cfg[a >> 2] = (m_cfg[a >> 2] & ~bm) | (d & bm);
      end
   endfunction

   task automatic wr(input logic [11:0] a, input logic [3:0] b, input logic [31:0] d, input string tag);
      @(negedge clk);
      req = 1'b1; we = 1'b1; addr = a; be_s = b; wdata = d;
      m_write(a, b, d);
      @(posedge clk);
      q_rd.push_back(1'b0); q_exp.push_back(32'h0); q_tag.push_back(tag);
   endtask

   task automatic rd(input logic [11:0] a, input string tag);
      @(negedge clk);
      req = 1'b1; we = 1'b0; addr = a; be_s = 4'h0; wdata = 32'h0;
      @(posedge clk);
      q_rd.push_back(1'b1); q_exp.push_back(m_read(a)); q_tag.push_back(tag);
   endtask

   task automatic set_own(input logic [NP-1:0] v);
      @(negedge clk);
      req = 1'b0; we = 1'b0;
      own = v;
   endtask

   // Monitor: one response due at each falling edge after a request edge
   bit          mon_rd;
   logic [31:0] mon_exp;
   string       mon_tag;
   always @(negedge clk) begin
      if (q_rd.size() != 0) begin
         mon_rd = q_rd.pop_front(); mon_exp = q_exp.pop_front(); mon_tag = q_tag.pop_front();
         n_chk++;
         if (ready_o !== 1'b1) begin
            n_fail++;
            $display("FAIL %s (R9 ready): actual=%b expected=1", mon_tag, ready_o);
         end else if (mon_rd && rdata_o !== mon_exp) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h", mon_tag, rdata_o, mon_exp);
         end
      end else if (rst_n === 1'b1 && ready_o !== 1'b0) begin
         n_chk++; n_fail++;
         $display("FAIL R9 stray ready: actual=%b expected=0", ready_o);
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_fail++;
      $display("FAIL R9 watchdog: actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
      $finish;
   end

   initial begin
      rst_n = 1'b0; req = 1'b0; we = 1'b0; addr = '0; be_s = '0; wdata = '0;
      own = '1;
      m_lock = '0; m_nmi = '0; m_hsw = '0;
      for (int i = 0; i < NP; i++) m_cfg[i] = 32'h0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      n_chk++;
      if (ready_o !== 1'b0 || rdata_o !== 32'h0) begin
         n_fail++;
         $display("FAIL R1 reset outputs: actual=%b/%h expected=0/00000000", ready_o, rdata_o);
      end

      // R1: reset values
      rd(12'h118, "R1 lock"); rd(12'h100, "R1 nmi"); rd(12'h104, "R1 hsw");
      rd(12'h000, "R1 cfg0"); rd(12'h05C, "R1 cfg23");

      // R2: lock all, reserved bits stay zero
      wr(12'h118, 4'hF, 32'hFFFF_FFFF, "R2 write lock");
      rd(12'h118, "R2 reserved zero");

      // R4: locked pad keeps fields, TX bit moves
      wr(12'h014, 4'hF, 32'hFFFF_FFFF, "R4 locked write");
      rd(12'h014, "R4 tx only set");
      wr(12'h014, 4'hF, 32'h0, "R4 clear");
      rd(12'h014, "R4 tx cleared");

      // R5: vector bits of locked pads hold
      wr(12'h100, 4'hF, 32'hFFFF_FFFF, "R5 nmi write");
      wr(12'h104, 4'hF, 32'hFFFF_FFFF, "R5 hsw write");
      rd(12'h100, "R5 nmi held"); rd(12'h104, "R5 hsw held");

      // R3: unlock pad 5 and write it
      wr(12'h118, 4'hF, 32'h00FF_FFDF, "R3 unlock pad5");
      rd(12'h118, "R3 lock readback");
      wr(12'h014, 4'hF, 32'hA5A5_5A5B, "R3 write pad5");
      rd(12'h014, "R3 pad5 written");

      // R6: pad 7 not host-owned ignores its lock
      set_own(24'hFF_FF7F);
      wr(12'h01C, 4'hF, 32'hCAFE_F00D, "R6 cfg7 write");
      rd(12'h01C, "R6 cfg7 free");
      wr(12'h100, 4'hF, 32'h0000_0080, "R6 nmi7 write");
      rd(12'h100, "R6 nmi7 free");

      // R7: ownership back to host protects on the next write
      set_own('1);
      wr(12'h01C, 4'hF, 32'h1234_5678, "R7 cfg7 write");
      rd(12'h01C, "R7 cfg7 held");
      wr(12'h100, 4'hF, 32'h0, "R7 nmi write");
      rd(12'h100, "R7 nmi7 held");

      // R8: byte strobes and mixed protection
      wr(12'h014, 4'h5, 32'h1122_3344, "R8 pad5 bytes 0,2");
      rd(12'h014, "R8 pad5 partial");
      wr(12'h024, 4'h1, 32'hFFFF_FFFF, "R8 locked pad9 byte0");
      rd(12'h024, "R8 pad9 tx only");
      wr(12'h118, 4'hF, 32'h0000_00FF, "R8 lock pads 0-7");
      wr(12'h104, 4'hF, 32'hFFFF_FFFF, "R8 hsw mixed");
      rd(12'h104, "R8 hsw unlocked bits");
      wr(12'h104, 4'h2, 32'h0, "R8 hsw clear byte1");
      rd(12'h104, "R8 hsw byte1 cleared");

      // R9: unmapped and misaligned accesses
      rd(12'h200, "R9 unmapped read");
      wr(12'h300, 4'hF, 32'hFFFF_FFFF, "R9 unmapped write");
      rd(12'h300, "R9 unmapped still zero");
      rd(12'h116, "R9 misaligned read");
      wr(12'h016, 4'hF, 32'hFFFF_FFFF, "R9 misaligned write");
      rd(12'h014, "R9 pad5 untouched");

      // R6: no pad host-owned, locked pad 0 fully writable
      set_own('0);
      wr(12'h000, 4'hF, 32'hDEAD_BEEF, "R6 cfg0 write");
      rd(12'h000, "R6 cfg0 free");

      set_own('0);
      repeat (3) @(negedge clk);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule